// File: doc/BRIEF.md
# Parallel Flash Command Sequencer

This block sits on the host side of an asynchronous byte-wide flash bus. It takes one request at a time over a valid/ready handshake. A request is a byte program, a sector erase, a whole-array erase or an identifier read. For each request the block plays out the unlock write cycles the flash expects, using strobe widths set as clock-cycle counts. For program and erase requests it then polls the flash until the operation finishes, and reports the result on a one-cycle completion pulse.

Completion is detected in one of two ways, chosen per request. The first reads the target address until bit 7 carries the expected value. The second reads twice in a row and finishes when bit 6 stops changing. A poll counter gives up after a parameterised number of reads and reports an error. The data bus is split into an output value, an output enable and an input value. The pad-level tristate buffer lives outside this block.

Top module: `flash_seq`

## Requirements
- R1: Operation code 0 (byte program) writes 5555h/AAh, 2AAAh/55h, 5555h/A0h, then the request address with the request data, in that order.
- R2: Operation code 1 (sector erase) writes 5555h/AAh, 2AAAh/55h, 5555h/80h, 5555h/AAh, 2AAAh/55h, then 30h at the request address.
- R3: Operation code 2 (full erase) writes the same five leading cycles as R2, then 10h at 5555h.
- R4: Operation code 3 (identifier read) writes 5555h/AAh, 2AAAh/55h, 5555h/90h. It then reads once at the request address and writes F0h at 5555h. It completes without error, returning the byte it read on done_data and making no further reads.
- R5: With req_toggle low, completion reads the request address until bit 7 equals the expected value: the programmed data bit 7 for a program, 1 for an erase. The completing byte is returned on done_data.
- R6: With req_toggle high, completion reads the request address repeatedly and finishes on the first read whose bit 6 equals bit 6 of the read just before it.
- R7: Every write cycle holds write enable low for at least ceil(max(35,35)/CLK_NS) cycles and high for at least ceil(30/CLK_NS) cycles between pulses. Address and data stay stable while write enable is low. The address stays stable for at least ceil(45/CLK_NS) cycles from the falling edge.
- R8: Output enable is high whenever write enable is low, and write enable is high whenever output enable is low.
- R9: fl_dq_oe is high only while chip enable is low and output enable is high, that is, only in write cycles.
- R10: If completion is not seen within POLL_MAX status reads, the block completes with done_err high after exactly POLL_MAX reads. If the final allowed read matches, it completes without error.
- R11: req_ready is high only when no request is in progress, and a request is taken on req_valid and req_ready. done_valid is a single-cycle pulse.
- R12: After reset, chip, output and write enable are high, fl_dq_oe is low and req_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request taken this cycle if valid |
| req_op | input | 2 | 0 program, 1 sector erase, 2 full erase, 3 identifier read |
| req_addr | input | AW | Target byte or sector address |
| req_data | input | 8 | Byte to program |
| req_toggle | input | 1 | 1 selects bit-6 toggle polling, 0 selects bit-7 polling |
| done_valid | output | 1 | One-cycle completion pulse |
| done_err | output | 1 | Poll limit reached, valid with done_valid |
| done_data | output | 8 | Last byte read, valid with done_valid |
| fl_addr | output | AW | Flash address |
| fl_dq_o | output | 8 | Write data toward flash |
| fl_dq_oe | output | 1 | Drive enable for fl_dq_o |
| fl_dq_i | input | 8 | Data read from flash |
| fl_ce_n | output | 1 | Chip enable, active low |
| fl_oe_n | output | 1 | Output enable, active low |
| fl_we_n | output | 1 | Write enable, active low |

## Verification
The two functions that can land on the same read are completion detection and the poll-limit abort. This happens when the flash model turns busy into finished exactly on the last read the limit allows. The bench sets the model's busy-read count so that the number of reads needed equals POLL_MAX, and one more than POLL_MAX. It then judges both the error flag and the exact number of reads seen on the bus. The first case must finish cleanly after POLL_MAX reads. The second must report an error after the same number of reads.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;

  typedef enum logic [1:0] {
    OP_PROG = 2'd0,
    OP_SECT = 2'd1,
    OP_CHIP = 2'd2,
    OP_ID   = 2'd3
  } fop_e;

  function automatic int ns2cyc(input int ns, input int clk_ns);
    int c;
    c = (ns + clk_ns - 1) / clk_ns;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/flash_cmd_table.sv
module flash_cmd_table
  import flash_seq_pkg::*;
#(
  parameter int AW = 19
) (
  input  fop_e          op,
  input  logic [2:0]    step,
  input  logic [AW-1:0] taddr,
  input  logic [7:0]    tdata,
  output logic [AW-1:0] c_addr,
  output logic [7:0]    c_data,
  output logic          c_rd,
  output logic          c_last
);
  localparam logic [AW-1:0] A_HI = AW'(20'h05555);
  localparam logic [AW-1:0] A_LO = AW'(20'h02AAA);

  always_comb begin
    c_addr = A_HI;
    c_data = 8'hAA;
    c_rd   = 1'b0;
    c_last = 1'b0;
    case (step)
      3'd0: begin c_addr = A_HI; c_data = 8'hAA; end
      3'd1: begin c_addr = A_LO; c_data = 8'h55; end
      3'd2: begin
        c_addr = A_HI;
        case (op)
          OP_PROG: c_data = 8'hA0;
          OP_ID:   c_data = 8'h90;
          default: c_data = 8'h80;
        endcase
      end
      3'd3: begin
        case (op)
          OP_PROG: begin c_addr = taddr; c_data = tdata; c_last = 1'b1; end
          OP_ID:   begin c_addr = taddr; c_rd = 1'b1; end
          default: begin c_addr = A_HI; c_data = 8'hAA; end
        endcase
      end
      3'd4: begin
        if (op == OP_ID) begin
          c_addr = A_HI; c_data = 8'hF0; c_last = 1'b1;
        end else begin
          c_addr = A_LO; c_data = 8'h55;
        end
      end
      default: begin
        c_last = 1'b1;
        if (op == OP_SECT) begin c_addr = taddr; c_data = 8'h30; end
        else               begin c_addr = A_HI;  c_data = 8'h10; end
      end
    endcase
  end
endmodule

// File: rtl/flash_strobe.sv
module flash_strobe #(
  parameter int AW   = 19,
  parameter int LOW  = 7,
  parameter int HIGH = 6,
  parameter int RD   = 14,
  parameter int GAP  = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          wr,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    wdata,
  output logic          done,
  output logic [7:0]    rdata,
  output logic [AW-1:0] fl_addr,
  output logic [7:0]    fl_dq_o,
  output logic          fl_dq_oe,
  input  logic [7:0]    fl_dq_i,
  output logic          fl_ce_n,
  output logic          fl_oe_n,
  output logic          fl_we_n
);
  localparam int CMAX = (LOW > HIGH ? LOW : HIGH) > (RD > GAP ? RD : GAP)
                      ? (LOW > HIGH ? LOW : HIGH) : (RD > GAP ? RD : GAP);
  localparam int CW = $clog2(CMAX + 1);

  typedef enum logic [2:0] {E_IDLE, E_SET, E_WLO, E_WHI, E_RLO, E_GAP} eph_e;
  eph_e          ph;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      ph <= E_IDLE; cnt <= '0; done <= 1'b0; rdata <= '0;
      fl_addr <= '0; fl_dq_o <= '0; fl_dq_oe <= 1'b0;
      fl_ce_n <= 1'b1; fl_oe_n <= 1'b1; fl_we_n <= 1'b1;
    end else begin
      done <= 1'b0;
      case (ph)
        E_IDLE: if (start) begin
          fl_addr <= addr;
          fl_ce_n <= 1'b0;
          if (wr) begin
            fl_dq_o <= wdata; fl_dq_oe <= 1'b1; ph <= E_SET;
          end else begin
            fl_oe_n <= 1'b0; cnt <= CW'(RD - 1); ph <= E_RLO;
          end
        end
        E_SET: begin fl_we_n <= 1'b0; cnt <= CW'(LOW - 1); ph <= E_WLO; end
        E_WLO: if (cnt == '0) begin
          fl_we_n <= 1'b1; cnt <= CW'(HIGH - 1); ph <= E_WHI;
        end else cnt <= cnt - 1'b1;
        E_WHI: if (cnt == '0) begin
          fl_ce_n <= 1'b1; fl_dq_oe <= 1'b0; cnt <= CW'(GAP - 1); ph <= E_GAP;
        end else cnt <= cnt - 1'b1;
        E_RLO: if (cnt == '0) begin
          rdata <= fl_dq_i; fl_oe_n <= 1'b1; fl_ce_n <= 1'b1;
          cnt <= CW'(GAP - 1); ph <= E_GAP;
        end else cnt <= cnt - 1'b1;
        E_GAP: if (cnt == '0) begin
          done <= 1'b1; ph <= E_IDLE;
        end else cnt <= cnt - 1'b1;
        default: ph <= E_IDLE;
      endcase
    end
  end

  p_oe_high_in_write_r8: assert property (@(posedge clk) disable iff (rst)
    !fl_we_n |-> fl_oe_n);
  p_we_high_in_read_r8: assert property (@(posedge clk) disable iff (rst)
    !fl_oe_n |-> fl_we_n);
  p_dq_drive_write_r9: assert property (@(posedge clk) disable iff (rst)
    fl_dq_oe |-> (!fl_ce_n && fl_oe_n));
  p_addr_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !fl_we_n |=> $stable(fl_addr));
  p_data_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !fl_we_n |=> ($stable(fl_dq_o) && fl_dq_oe));
endmodule

// File: rtl/flash_seq.sv
module flash_seq
  import flash_seq_pkg::*;
#(
  parameter int AW        = 19,
  parameter int CLK_NS    = 5,
  parameter int T_WP_NS   = 35,
  parameter int T_WPH_NS  = 30,
  parameter int T_DS_NS   = 35,
  parameter int T_AH_NS   = 45,
  parameter int T_ACC_NS  = 70,
  parameter int T_GAP_NS  = 20,
  parameter int POLL_MAX  = 1000
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [1:0]    req_op,
  input  logic [AW-1:0] req_addr,
  input  logic [7:0]    req_data,
  input  logic          req_toggle,
  output logic          done_valid,
  output logic          done_err,
  output logic [7:0]    done_data,
  output logic [AW-1:0] fl_addr,
  output logic [7:0]    fl_dq_o,
  output logic          fl_dq_oe,
  input  logic [7:0]    fl_dq_i,
  output logic          fl_ce_n,
  output logic          fl_oe_n,
  output logic          fl_we_n
);
  localparam int LOWC  = imax(ns2cyc(T_WP_NS, CLK_NS), ns2cyc(T_DS_NS, CLK_NS));
  localparam int HIGHC = imax(ns2cyc(T_WPH_NS, CLK_NS), ns2cyc(T_AH_NS, CLK_NS) - LOWC);
  localparam int RDC   = ns2cyc(T_ACC_NS, CLK_NS);
  localparam int GAPC  = ns2cyc(T_GAP_NS, CLK_NS);
  localparam int PCW   = $clog2(POLL_MAX + 1);

  typedef enum logic [1:0] {S_IDLE, S_CMD, S_POLL} st_e;
  st_e            state;
  fop_e           op;
  logic [AW-1:0]  taddr;
  logic [7:0]     tdata, rbyte;
  logic           tog, issued, have_prev, prev6;
  logic [2:0]     step;
  logic [PCW-1:0] pcnt;

  logic           eng_start, eng_wr, eng_done;
  logic [AW-1:0]  eng_addr;
  logic [7:0]     eng_data, eng_rdata;
  logic [AW-1:0]  c_addr;
  logic [7:0]     c_data;
  logic           c_rd, c_last, hit;

  flash_cmd_table #(.AW(AW)) u_tbl (
    .op(op), .step(step), .taddr(taddr), .tdata(tdata),
    .c_addr(c_addr), .c_data(c_data), .c_rd(c_rd), .c_last(c_last)
  );

  flash_strobe #(.AW(AW), .LOW(LOWC), .HIGH(HIGHC), .RD(RDC), .GAP(GAPC)) u_strb (
    .clk(clk), .rst(rst), .start(eng_start), .wr(eng_wr), .addr(eng_addr),
    .wdata(eng_data), .done(eng_done), .rdata(eng_rdata),
    .fl_addr(fl_addr), .fl_dq_o(fl_dq_o), .fl_dq_oe(fl_dq_oe), .fl_dq_i(fl_dq_i),
    .fl_ce_n(fl_ce_n), .fl_oe_n(fl_oe_n), .fl_we_n(fl_we_n)
  );

  assign req_ready = (state == S_IDLE);

  always_comb begin
    if (tog) hit = have_prev && (eng_rdata[6] == prev6);
    else     hit = eng_rdata[7] == ((op == OP_PROG) ? tdata[7] : 1'b1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= S_IDLE; op <= OP_PROG; taddr <= '0; tdata <= '0; tog <= 1'b0;
      rbyte <= '0; issued <= 1'b0; have_prev <= 1'b0; prev6 <= 1'b0;
      step <= '0; pcnt <= '0; eng_start <= 1'b0; eng_wr <= 1'b0;
      eng_addr <= '0; eng_data <= '0;
      done_valid <= 1'b0; done_err <= 1'b0; done_data <= '0;
    end else begin
      eng_start  <= 1'b0;
      done_valid <= 1'b0;
      done_err   <= 1'b0;
      case (state)
        S_IDLE: if (req_valid) begin
          op <= fop_e'(req_op); taddr <= req_addr; tdata <= req_data;
          tog <= req_toggle; step <= '0; issued <= 1'b0; state <= S_CMD;
        end
        S_CMD: begin
          if (!issued) begin
            eng_start <= 1'b1; eng_wr <= !c_rd; eng_addr <= c_addr;
            eng_data <= c_data; issued <= 1'b1;
          end else if (eng_done) begin
            issued <= 1'b0;
            if (c_rd) rbyte <= eng_rdata;
            if (c_last) begin
              if (op == OP_ID) begin
                done_valid <= 1'b1; done_data <= rbyte; state <= S_IDLE;
              end else begin
                pcnt <= '0; have_prev <= 1'b0; state <= S_POLL;
              end
            end else step <= step + 1'b1;
          end
        end
        S_POLL: begin
          if (!issued) begin
            eng_start <= 1'b1; eng_wr <= 1'b0; eng_addr <= taddr; issued <= 1'b1;
          end else if (eng_done) begin
            issued <= 1'b0; prev6 <= eng_rdata[6]; have_prev <= 1'b1;
            if (hit || pcnt == PCW'(POLL_MAX - 1)) begin
              done_valid <= 1'b1; done_err <= !hit; done_data <= eng_rdata;
              state <= S_IDLE;
            end else pcnt <= pcnt + 1'b1;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  p_ready_drop_r11: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> !req_ready);
  p_done_pulse_r11: assert property (@(posedge clk) disable iff (rst)
    done_valid |=> !done_valid);
  p_err_with_done_r10: assert property (@(posedge clk) disable iff (rst)
    done_err |-> done_valid);
  p_idle_bus_quiet_r12: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> (fl_ce_n && !fl_dq_oe && fl_we_n));
endmodule

// File: tb/tb_flash_seq.sv
module tb_flash_seq;
  localparam int AW = 19;
  localparam int PM = 8;
  localparam int LOWMIN = 7, HIGHMIN = 6, AHMIN = 9;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic          req_valid = 1'b0, req_toggle = 1'b0;
  logic [1:0]    req_op = '0;
  logic [AW-1:0] req_addr = '0;
  logic [7:0]    req_data = '0;
  logic          req_ready, done_valid, done_err;
  logic [7:0]    done_data, fl_dq_o, mdl_q;
  logic [AW-1:0] fl_addr;
  logic          fl_dq_oe, fl_ce_n, fl_oe_n, fl_we_n;

  flash_seq #(.AW(AW), .POLL_MAX(PM)) dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_addr(req_addr), .req_data(req_data), .req_toggle(req_toggle),
    .done_valid(done_valid), .done_err(done_err), .done_data(done_data),
    .fl_addr(fl_addr), .fl_dq_o(fl_dq_o), .fl_dq_oe(fl_dq_oe), .fl_dq_i(mdl_q),
    .fl_ce_n(fl_ce_n), .fl_oe_n(fl_oe_n), .fl_we_n(fl_we_n)
  );

  int total = 0, bad = 0;
  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // flash model and bus monitor
  int            m_kind = 0, m_busy = 0, m_idx = 0, nreads = 0, nwr = 0;
  logic [7:0]    m_pd = '0;
  logic [AW-1:0] la [0:7];
  logic [7:0]    ld [0:7];
  logic          p_we = 1'b1, p_oe = 1'b1, trk = 1'b0;
  int            lowrun = 0, highrun = 0, hold = 0;
  int            min_low = 1000, min_high = 1000, min_hold = 1000, viol = 0;
  logic [AW-1:0] f_addr;
  logic [7:0]    f_dq;

  always @(negedge clk) begin
    if (!rst) begin
      if (!fl_we_n && !fl_oe_n) viol++;
      if (fl_dq_oe && (fl_ce_n || !fl_oe_n)) viol++;
      if (p_we && !fl_we_n) begin
        f_addr = fl_addr; f_dq = fl_dq_o; trk = 1'b1; hold = 0;
        if (highrun > 0 && highrun < min_high && nwr > 0) min_high = highrun;
        highrun = 0;
        if (nwr < 8) la[nwr] = fl_addr;
      end
      if (!p_we && fl_we_n) begin
        if (lowrun < min_low) min_low = lowrun;
        lowrun = 0;
        if (fl_dq_o != f_dq || !fl_dq_oe) viol++;
        if (nwr < 8) ld[nwr] = fl_dq_o;
        nwr++;
      end
      if (!fl_we_n) lowrun++; else highrun++;
      if (trk) begin
        if (fl_addr == f_addr && !fl_ce_n) hold++;
        else begin
          if (hold < min_hold) min_hold = hold;
          trk = 1'b0;
        end
      end
      if (p_oe && !fl_oe_n) begin
        nreads++;
        if (m_kind == 3) mdl_q = fl_addr[0] ? 8'hA7 : 8'h3C;
        else if (m_busy > 0) begin
          mdl_q = {(m_kind == 0) ? ~m_pd[7] : 1'b0, m_idx[0], 6'h00};
          m_idx++; m_busy--;
        end else mdl_q = (m_kind == 0) ? m_pd : 8'hFF;
      end
      p_we = fl_we_n; p_oe = fl_oe_n;
    end
  end

  function automatic logic [AW-1:0] exp_a(input int op, input int i, input logic [AW-1:0] a);
    if (i == 1 || i == 4) return (op == 3 && i == 4) ? AW'(20'h05555) : AW'(20'h02AAA);
    if (op == 0 && i == 3) return a;
    if (op == 1 && i == 5) return a;
    return AW'(20'h05555);
  endfunction

  function automatic logic [7:0] exp_d(input int op, input int i, input logic [7:0] d);
    case (i)
      0: return 8'hAA;
      1: return 8'h55;
      2: return (op == 0) ? 8'hA0 : (op == 3) ? 8'h90 : 8'h80;
      3: return (op == 0) ? d : 8'hAA;
      4: return (op == 3) ? 8'hF0 : 8'h55;
      default: return (op == 1) ? 8'h30 : 8'h10;
    endcase
  endfunction

  function automatic int need_reads(input int op, input bit tg, input int b, input logic [7:0] d);
    logic d6, s6;
    if (!tg) return b + 1;
    d6 = (op == 0) ? d[6] : 1'b1;
    s6 = 1'((b - 1) & 1);
    return (b > 0 && d6 == s6) ? b + 1 : b + 2;
  endfunction

  task automatic run_op(input int op, input logic [AW-1:0] a, input logic [7:0] d,
                        input bit tg, input int b);
    int nw, nr_exp, nd, wd;
    bit e_err, got;
    string tag;
    tag = (op == 0) ? "R1" : (op == 1) ? "R2" : (op == 2) ? "R3" : "R4";
    m_kind = op; m_busy = b; m_idx = 0; m_pd = d; nreads = 0; nwr = 0;
    @(negedge clk);
    req_valid = 1'b1; req_op = 2'(op); req_addr = a; req_data = d; req_toggle = tg;
    @(negedge clk);
    req_valid = 1'b0;
    check(!req_ready, "R11 ready low after accept", req_ready, 0);
    got = 1'b0; wd = 0;
    while (!got && wd < 20000) begin
      @(negedge clk);
      if (done_valid) got = 1'b1;
      wd++;
    end
    check(got, "R11 watchdog done", got, 1);
    if (!got) return;
    nw = (op == 0) ? 4 : (op == 3) ? 5 : 6;
    nw = (op == 3) ? 4 : nw;
    check(nwr == nw, {tag, " write count"}, nwr, nw);
    for (int i = 0; i < 6 && i < nw; i++) begin
      int si;
      si = (op == 3 && i == 3) ? 4 : i;
      check(la[i] == exp_a(op, si, a), {tag, " write addr"}, la[i], exp_a(op, si, a));
      check(ld[i] == exp_d(op, si, d), {tag, " write data"}, ld[i], exp_d(op, si, d));
    end
    if (op == 3) begin
      e_err = 1'b0; nr_exp = 1;
      check(done_data == (a[0] ? 8'hA7 : 8'h3C), "R4 id byte", done_data, a[0] ? 8'hA7 : 8'h3C);
    end else begin
      nd = need_reads(op, tg, b, d);
      e_err = nd > PM;
      nr_exp = e_err ? PM : nd;
      if (!e_err)
        check(done_data == ((op == 0) ? d : 8'hFF), tg ? "R6 final byte" : "R5 final byte",
              done_data, (op == 0) ? d : 8'hFF);
    end
    check(nreads == nr_exp, tg ? "R6 poll reads" : "R5 poll reads", nreads, nr_exp);
    check(done_err == e_err, "R10 error flag", done_err, e_err);
    @(negedge clk);
    check(!done_valid, "R11 done one cycle", done_valid, 0);
    check(req_ready, "R11 ready back", req_ready, 1);
  endtask

  initial begin
    void'($urandom(32'h5EED));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(fl_ce_n && fl_oe_n && fl_we_n && !fl_dq_oe && req_ready, "R12 reset state",
          {fl_ce_n, fl_oe_n, fl_we_n, fl_dq_oe, req_ready}, 5'b11101);
    run_op(0, 19'h12345, 8'h5A, 1'b0, 3);
    run_op(0, 19'h00007, 8'hC3, 1'b1, 5);
    run_op(1, 19'h4ABCD, 8'h00, 1'b1, 4);
    run_op(2, 19'h00000, 8'h00, 1'b0, 2);
    run_op(3, 19'h00000, 8'h00, 1'b0, 0);
    run_op(3, 19'h00001, 8'h00, 1'b0, 0);
    run_op(0, 19'h7FFFF, 8'h81, 1'b0, PM - 1);  // R10 completes on last allowed read
    run_op(1, 19'h30000, 8'h00, 1'b0, PM);      // R10 one read short
    run_op(2, 19'h00000, 8'h00, 1'b1, 40);      // R10 toggle timeout
    for (int k = 0; k < 20; k++)
      run_op(int'($urandom_range(0, 3)), AW'($urandom), 8'($urandom),
             1'($urandom_range(0, 1)), int'($urandom_range(0, 9)));
    check(viol == 0, "R8 R9 bus rule violations", viol, 0);
    check(min_low >= LOWMIN, "R7 write low width", min_low, LOWMIN);
    check(min_high >= HIGHMIN, "R7 write high width", min_high, HIGHMIN);
    check(min_hold >= AHMIN, "R7 address hold", min_hold, AHMIN);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #2_000_000;
    total++; bad++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule